// File: doc/BRIEF.md
# DC-Only 4x4 Reconstruction Adder

This block finishes reconstruction of 4x4 pixel blocks whose residual holds nothing but a DC term. For each block it fetches one signed 16-bit coefficient and zeroes that coefficient in its store. It turns the coefficient into a rounded offset and adds the offset to every one of the sixteen 8-bit prediction pixels. The saturated sums are written back over the prediction. Prediction, AC terms and full inverse transforms belong to other blocks.

A controller sets a pixel origin, a row stride, a coefficient address and a mode, then pulses `start`. The block can process one block, a horizontal strip of four luma blocks, or a 2x2 group of four chroma blocks. It handles one 4-pixel row per cycle, using a pixel memory port with a one-cycle read latency and a coefficient port with read and clear. It pulses `done` once the final row has been written.

Top module: `dc_recon_adder`

## Requirements
- R1: The offset applied to a block is (dc + 4) shifted right arithmetically by 3, where dc is the signed 16-bit coefficient read for that block.
- R2: Each of the 16 pixels of a block is replaced by pixel + offset, clamped to 0..255. In a 32-bit row word, bits 8j+7..8j hold the pixel at row address + j.
- R3: A coefficient is read with `coef_rd_en`. In the next cycle `coef_clr_en` is high with the same `coef_addr`, and that location is written to zero.
- R4: Row r of a block is read at block origin + r * stride, one row per cycle and rows in order. Each row is written back to the same address in the cycle after its read.
- R5: `mode` 0 and `mode` 3 process a single block at `pix_base`, using the coefficient at `coef_base`.
- R6: `mode` 1 processes four blocks at `pix_base` + 4i, for i = 0..3 in that order. Block i uses the coefficient at `coef_base` + 16i.
- R7: `mode` 2 processes four blocks in this order: origin, origin + 4, origin + 4 * stride, origin + 4 * stride + 4. Block i uses the coefficient at `coef_base` + 16i. Pixels outside the processed blocks are left unchanged.
- R8: `done` is high for one cycle, exactly 7 * N cycles after the edge that captured `start`, where N is the number of blocks. This is one cycle after the last row write.
- R9: A `start` pulse that arrives while processing is under way is ignored, together with any changes to `mode`, `pix_base` or `coef_base` made at that time.
- R10: During and right after reset, `pix_rd_en`, `pix_wr_en`, `coef_rd_en`, `coef_clr_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run; captured only when idle |
| mode | input | 2 | 0/3 single, 1 luma strip, 2 chroma 2x2 |
| pix_base | input | AW | Pixel address of the first block's top-left byte |
| pix_stride | input | AW | Byte distance between pixel rows |
| coef_base | input | CW | Coefficient address of the first block |
| pix_rd_en | output | 1 | Row read request |
| pix_rd_addr | output | AW | Row read address |
| pix_rd_data | input | 4*8 | Row data, valid the cycle after the request |
| pix_wr_en | output | 1 | Row write strobe |
| pix_wr_addr | output | AW | Row write address |
| pix_wr_data | output | 4*8 | Saturated row data |
| coef_rd_en | output | 1 | Coefficient read request |
| coef_addr | output | CW | Coefficient address for read and clear |
| coef_rd_data | input | 16 | Coefficient, valid the cycle after the request |
| coef_clr_en | output | 1 | Write zero to `coef_addr` |
| done | output | 1 | One-cycle completion pulse |

## Verification
Single blocks are swept across a coefficient list that straddles each rounding step (-5, -4, -3, 3, 4, 5, 11, 12) and reaches both 16-bit extremes. They run over a ramp, an alternating 0/255 pattern, an all-zero field and an all-255 field. Together these separate a wrong rounding constant or a logical shift from the correct arithmetic shift, and expose a missing clamp at either end. Luma strips and chroma groups use a distinct coefficient per block and are checked against a full memory image. A wrong block order, a wrong vertical step or stray writes outside the blocks therefore all show up. Runs that pulse `start` with a different mode and base mid-run confirm that the captured configuration holds.

// File: rtl/dcadd_pkg.sv
`timescale 1ns/1ps
package dcadd_pkg;

    localparam int PIX_W   = 8;
    localparam int DC_W    = 16;
    localparam int OFS_W   = DC_W - 2;
    localparam int SUM_W   = OFS_W + 1;
    localparam int PIX_MAX = (1 << PIX_W) - 1;
    localparam int QUAD    = 4;

    typedef enum logic [1:0] {
        MODE_SINGLE      = 2'd0,
        MODE_LUMA_STRIP  = 2'd1,
        MODE_CHROMA_QUAD = 2'd2,
        MODE_SINGLE_ALT  = 2'd3
    } blk_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COEF,
        ST_OFS,
        ST_ROW,
        ST_DRAIN
    } walk_state_e;

    // Rounded DC offset: (dc + 4) >>> 3, computed one bit wider than dc.
    function automatic logic signed [OFS_W-1:0] dc_offset(input logic signed [DC_W-1:0] dc);
        logic signed [DC_W:0] biased;
        logic signed [DC_W:0] shifted;
        biased  = {dc[DC_W-1], dc} + (DC_W+1)'(4);
        shifted = biased >>> 3;
        return shifted[OFS_W-1:0];
    endfunction

    // Pixel plus signed offset, clamped to the unsigned pixel range.
    function automatic logic [PIX_W-1:0] sat_pixel(input logic [PIX_W-1:0] pix,
                                                   input logic signed [OFS_W-1:0] ofs);
        logic signed [SUM_W-1:0] sum;
        sum = $signed({{(SUM_W-PIX_W){1'b0}}, pix}) + $signed({ofs[OFS_W-1], ofs});
        if (sum[SUM_W-1])
            return '0;
        else if (sum > SUM_W'(PIX_MAX))
            return PIX_W'(PIX_MAX);
        else
            return sum[PIX_W-1:0];
    endfunction

    function automatic logic multi_block(input blk_mode_e m);
        return (m == MODE_LUMA_STRIP) || (m == MODE_CHROMA_QUAD);
    endfunction

endpackage

// File: rtl/dcadd_offset.sv
`timescale 1ns/1ps
module dcadd_offset
    import dcadd_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [DC_W-1:0]         coef,
    output logic signed [OFS_W-1:0] ofs
);
    always_ff @(posedge clk) begin
        if (rst)
            ofs <= '0;
        else if (load)
            ofs <= dc_offset($signed(coef));
    end
endmodule

// File: rtl/dcadd_lane_sat.sv
`timescale 1ns/1ps
module dcadd_lane_sat
    import dcadd_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [LANES*PIX_W-1:0]  pix_in,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [LANES*PIX_W-1:0]  pix_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign pix_out[g*PIX_W +: PIX_W] = sat_pixel(pix_in[g*PIX_W +: PIX_W], ofs);
    end
endmodule

// File: rtl/dcadd_walker.sv
`timescale 1ns/1ps
module dcadd_walker
    import dcadd_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 10,
    parameter int BLK_DIM = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [1:0]    mode,
    input  logic [AW-1:0] pix_base,
    input  logic [AW-1:0] pix_stride,
    input  logic [CW-1:0] coef_base,
    output logic          coef_rd_en,
    output logic          coef_clr_en,
    output logic [CW-1:0] coef_addr,
    output logic          ofs_load,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          done
);
    localparam int ROW_W     = (BLK_DIM > 1) ? $clog2(BLK_DIM) : 1;
    localparam int LAST_ROW  = BLK_DIM - 1;
    localparam int COEF_STEP = BLK_DIM * BLK_DIM;
    localparam int BLK_W     = $clog2(QUAD);

    walk_state_e          state;
    blk_mode_e            mode_q;
    logic [AW-1:0]        stride_q;
    logic [AW-1:0]        org0_q;
    logic [AW-1:0]        blk_org_q;
    logic [AW-1:0]        row_ptr_q;
    logic [CW-1:0]        coef_ptr_q;
    logic [ROW_W-1:0]     row_q;
    logic [BLK_W-1:0]     blk_q;
    logic                 done_q;
    logic                 last_blk;
    logic [AW-1:0]        next_org;

    assign last_blk = multi_block(mode_q) ? (blk_q == BLK_W'(QUAD-1)) : 1'b1;
    // Chroma: after the top pair, drop BLK_DIM rows back to the left column.
    assign next_org = (mode_q == MODE_CHROMA_QUAD && blk_q == BLK_W'(1))
                    ? org0_q + AW'(stride_q * AW'(BLK_DIM))
                    : blk_org_q + AW'(BLK_DIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= ST_IDLE;
            mode_q     <= MODE_SINGLE;
            stride_q   <= '0;
            org0_q     <= '0;
            blk_org_q  <= '0;
            row_ptr_q  <= '0;
            coef_ptr_q <= '0;
            row_q      <= '0;
            blk_q      <= '0;
            done_q     <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        mode_q     <= blk_mode_e'(mode);
                        stride_q   <= pix_stride;
                        org0_q     <= pix_base;
                        blk_org_q  <= pix_base;
                        row_ptr_q  <= pix_base;
                        coef_ptr_q <= coef_base;
                        blk_q      <= '0;
                        state      <= ST_COEF;
                    end
                end
                ST_COEF: state <= ST_OFS;
                ST_OFS: begin
                    row_q <= '0;
                    state <= ST_ROW;
                end
                ST_ROW: begin
                    row_ptr_q <= row_ptr_q + stride_q;
                    row_q     <= row_q + ROW_W'(1);
                    if (row_q == ROW_W'(LAST_ROW))
                        state <= ST_DRAIN;
                end
                ST_DRAIN: begin
                    if (last_blk) begin
                        done_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        blk_org_q  <= next_org;
                        row_ptr_q  <= next_org;
                        coef_ptr_q <= coef_ptr_q + CW'(COEF_STEP);
                        blk_q      <= blk_q + BLK_W'(1);
                        state      <= ST_COEF;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign coef_rd_en  = (state == ST_COEF);
    assign coef_clr_en = (state == ST_OFS);
    assign ofs_load    = (state == ST_OFS);
    assign coef_addr   = coef_ptr_q;
    assign rd_en       = (state == ST_ROW);
    assign rd_addr     = row_ptr_q;
    assign done        = done_q;
endmodule

// File: rtl/dc_recon_adder.sv
`timescale 1ns/1ps
module dc_recon_adder
    import dcadd_pkg::*;
#(
    parameter int AW      = 16,
    parameter int CW      = 10,
    parameter int BLK_DIM = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     start,
    input  logic [1:0]               mode,
    input  logic [AW-1:0]            pix_base,
    input  logic [AW-1:0]            pix_stride,
    input  logic [CW-1:0]            coef_base,
    output logic                     pix_rd_en,
    output logic [AW-1:0]            pix_rd_addr,
    input  logic [BLK_DIM*PIX_W-1:0] pix_rd_data,
    output logic                     pix_wr_en,
    output logic [AW-1:0]            pix_wr_addr,
    output logic [BLK_DIM*PIX_W-1:0] pix_wr_data,
    output logic                     coef_rd_en,
    output logic [CW-1:0]            coef_addr,
    input  logic [DC_W-1:0]          coef_rd_data,
    output logic                     coef_clr_en,
    output logic                     done
);
    logic                    ofs_load;
    logic signed [OFS_W-1:0] ofs;
    logic                    wr_pend_q;
    logic [AW-1:0]           wr_addr_q;

    dcadd_walker #(.AW(AW), .CW(CW), .BLK_DIM(BLK_DIM)) u_walk (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .mode       (mode),
        .pix_base   (pix_base),
        .pix_stride (pix_stride),
        .coef_base  (coef_base),
        .coef_rd_en (coef_rd_en),
        .coef_clr_en(coef_clr_en),
        .coef_addr  (coef_addr),
        .ofs_load   (ofs_load),
        .rd_en      (pix_rd_en),
        .rd_addr    (pix_rd_addr),
        .done       (done)
    );

    dcadd_offset u_ofs (
        .clk (clk),
        .rst (rst),
        .load(ofs_load),
        .coef(coef_rd_data),
        .ofs (ofs)
    );

    // Write stage trails the read stage by the memory's one-cycle latency.
    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend_q <= 1'b0;
            wr_addr_q <= '0;
        end else begin
            wr_pend_q <= pix_rd_en;
            wr_addr_q <= pix_rd_addr;
        end
    end

    dcadd_lane_sat #(.LANES(BLK_DIM)) u_sat (
        .pix_in (pix_rd_data),
        .ofs    (ofs),
        .pix_out(pix_wr_data)
    );

    assign pix_wr_en   = wr_pend_q;
    assign pix_wr_addr = wr_addr_q;
endmodule

// File: rtl/dcadd_checker.sv
`timescale 1ns/1ps
module dcadd_checker #(
    parameter int AW = 16,
    parameter int CW = 10
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] pix_stride,
    input logic          pix_rd_en,
    input logic [AW-1:0] pix_rd_addr,
    input logic          pix_wr_en,
    input logic [AW-1:0] pix_wr_addr,
    input logic          coef_rd_en,
    input logic          coef_clr_en,
    input logic [CW-1:0] coef_addr,
    input logic          done
);
    // R3
    a_r3_clear_follows_read: assert property (@(posedge clk) disable iff (rst)
        coef_rd_en |=> coef_clr_en && coef_addr == $past(coef_addr));
    // R3
    a_r3_clear_only_after_read: assert property (@(posedge clk) disable iff (rst)
        coef_clr_en |-> $past(coef_rd_en));
    // R4
    a_r4_write_same_row: assert property (@(posedge clk) disable iff (rst)
        pix_rd_en |=> pix_wr_en && pix_wr_addr == $past(pix_rd_addr));
    // R4
    a_r4_row_step: assert property (@(posedge clk) disable iff (rst)
        pix_rd_en && $past(pix_rd_en) |-> pix_rd_addr == $past(pix_rd_addr) + $past(pix_stride));
    // R8
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8
    a_r8_done_after_write: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(pix_wr_en) && !pix_rd_en && !coef_rd_en);
endmodule

bind dc_recon_adder dcadd_checker #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pix_stride (pix_stride),
    .pix_rd_en  (pix_rd_en),
    .pix_rd_addr(pix_rd_addr),
    .pix_wr_en  (pix_wr_en),
    .pix_wr_addr(pix_wr_addr),
    .coef_rd_en (coef_rd_en),
    .coef_clr_en(coef_clr_en),
    .coef_addr  (coef_addr),
    .done       (done)
);

// File: tb/sim_dc_recon_adder.sv
`timescale 1ns/1ps
module sim_dc_recon_adder;
    localparam int AW = 16;
    localparam int CW = 10;
    localparam int PM = 1024;
    localparam int CM = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [AW-1:0] pix_base = '0;
    logic [AW-1:0] pix_stride = 16'd16;
    logic [CW-1:0] coef_base = '0;
    logic          pix_rd_en, pix_wr_en, coef_rd_en, coef_clr_en, done;
    logic [AW-1:0] pix_rd_addr, pix_wr_addr;
    logic [31:0]   pix_rd_data = '0;
    logic [31:0]   pix_wr_data;
    logic [CW-1:0] coef_addr;
    logic [15:0]   coef_rd_data = '0;

    logic [7:0]  pmem [PM];
    logic [15:0] cmem [CM];
    int          epix [PM];
    int          ecoef [CM];

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    dc_recon_adder #(.AW(AW), .CW(CW), .BLK_DIM(4)) u0 (
        .clk(clk), .rst(rst), .start(start), .mode(mode),
        .pix_base(pix_base), .pix_stride(pix_stride), .coef_base(coef_base),
        .pix_rd_en(pix_rd_en), .pix_rd_addr(pix_rd_addr), .pix_rd_data(pix_rd_data),
        .pix_wr_en(pix_wr_en), .pix_wr_addr(pix_wr_addr), .pix_wr_data(pix_wr_data),
        .coef_rd_en(coef_rd_en), .coef_addr(coef_addr), .coef_rd_data(coef_rd_data),
        .coef_clr_en(coef_clr_en), .done(done)
    );

    // Memory models: one-cycle read latency, byte j of a row word at address + j.
    always @(posedge clk) begin
        if (pix_rd_en)
            for (int j = 0; j < 4; j++)
                pix_rd_data[8*j +: 8] <= pmem[(int'(pix_rd_addr) + j) % PM];
        if (pix_wr_en)
            for (int j = 0; j < 4; j++)
                pmem[(int'(pix_wr_addr) + j) % PM] <= pix_wr_data[8*j +: 8];
        if (coef_rd_en)
            coef_rd_data <= cmem[int'(coef_addr) % CM];
        if (coef_clr_en)
            cmem[int'(coef_addr) % CM] <= 16'd0;
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int pattern(input int i, input int seed);
        if (seed == 1000) return 0;
        if (seed == 1001) return 255;
        if (seed == 1002) return (i % 2 == 0) ? 0 : 255;
        return ((i * 37 + seed * 53) ^ (seed * 3)) & 255;
    endfunction

    // Fill memories and load per-block coefficients at cbase + 16*b.
    task automatic prepare(input int seed, input int cbase, input int nb, input int dc[4]);
        for (int i = 0; i < PM; i++) begin
            pmem[i] = 8'(pattern(i, seed));
            epix[i] = pattern(i, seed);
        end
        for (int i = 0; i < CM; i++) begin
            cmem[i]  = 16'(i * 97 + 5);
            ecoef[i] = i * 97 + 5;
        end
        for (int b = 0; b < nb; b++) begin
            cmem[(cbase + 16 * b) % CM]  = 16'(dc[b]);
            ecoef[(cbase + 16 * b) % CM] = dc[b] & 16'hFFFF;
        end
    endtask

    // Expected result, straight from R1, R2, R5, R6, R7.
    task automatic model(input int md, input int base, input int stride, input int cbase);
        int nb;
        nb = (md == 1 || md == 2) ? 4 : 1;
        for (int b = 0; b < nb; b++) begin
            int org, ci, dc, ofs;
            if (md == 2) org = base + (b % 2) * 4 + (b / 2) * 4 * stride;
            else         org = base + 4 * b;
            ci = (cbase + 16 * b) % CM;
            dc = ecoef[ci];
            if (dc >= 32768) dc = dc - 65536;
            ecoef[ci] = 0;
            ofs = (dc + 4) >>> 3;
            for (int r = 0; r < 4; r++)
                for (int c = 0; c < 4; c++) begin
                    int a, v;
                    a = (org + r * stride + c) % PM;
                    v = epix[a] + ofs;
                    if (v < 0) v = 0;
                    if (v > 255) v = 255;
                    epix[a] = v;
                end
        end
    endtask

    task automatic run(input string req, input int md, input int base, input int stride,
                       input int cbase, input int seed, input int dc[4], input bit glitch);
        int nb, cnt, bad_p, bad_c, first_a;
        nb = (md == 1 || md == 2) ? 4 : 1;
        prepare(seed, cbase, nb, dc);
        model(md, base, stride, cbase);
        @(negedge clk);
        mode = 2'(md); pix_base = AW'(base); pix_stride = AW'(stride); coef_base = CW'(cbase);
        start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (!done && cnt < 200) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (glitch && cnt == 3) begin
                start = 1'b1;
                mode = 2'((md + 1) % 3);
                pix_base = AW'(base + 40);
                coef_base = CW'(cbase + 3);
            end else begin
                start = 1'b0;
            end
        end
        check({req, " R8"}, "cycles to done", cnt, 7 * nb);
        @(posedge clk);
        @(negedge clk);
        check("R8", "done width", int'(done), 0);
        bad_p = 0; first_a = -1;
        for (int i = 0; i < PM; i++)
            if (int'(pmem[i]) != epix[i]) begin
                if (bad_p == 0) first_a = i;
                bad_p++;
            end
        if (bad_p != 0)
            check({req, " R2"}, $sformatf("pixel @%0d", first_a), int'(pmem[first_a]), epix[first_a]);
        else
            check({req, " R2"}, "pixel image", 0, 0);
        bad_c = 0;
        for (int i = 0; i < CM; i++)
            if (int'(cmem[i]) != ecoef[i]) bad_c++;
        check({req, " R3"}, "coef mismatches", bad_c, 0);
    endtask

    initial begin
        #900000;
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int dcl[22];
        int dq[4];
        dcl = '{-32768, -32767, -2048, -1000, -40, -13, -12, -5, -4, -3, -1,
                0, 1, 3, 4, 5, 11, 12, 100, 1019, 2040, 32767};

        // R10: reset state
        repeat (3) @(negedge clk);
        check("R10", "rd/wr/coef/done during reset",
              int'({pix_rd_en, pix_wr_en, coef_rd_en, coef_clr_en, done}), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10", "outputs after reset",
              int'({pix_rd_en, pix_wr_en, coef_rd_en, coef_clr_en, done}), 0);

        // R1/R2/R5: single-block sweep over rounding steps and pixel fields
        for (int k = 0; k < 22; k++) begin
            dq = '{dcl[k], 0, 0, 0};
            run("R1 R5", 0, 64 + k, 12, k, k, dq, 1'b0);
            run("R2 ramp", 0, 200, 16, 7, 1002, dq, 1'b0);
            if (dcl[k] < 0) run("R2 floor", 0, 30, 8, 2, 1001, dq, 1'b0);
            else            run("R2 ceil", 0, 30, 8, 2, 1000, dq, 1'b0);
        end
        dq = '{-300, 0, 0, 0};
        run("R2 floor", 0, 30, 8, 2, 1000, dq, 1'b0);
        dq = '{300, 0, 0, 0};
        run("R2 ceil", 0, 30, 8, 2, 1001, dq, 1'b0);
        dq = '{77, 0, 0, 0};
        run("R5 mode3", 3, 500, 20, 9, 4, dq, 1'b0);

        // R6: luma strip
        dq = '{-200, 37, 700, -9};
        run("R6 luma", 1, 40, 24, 4, 6, dq, 1'b0);
        dq = '{32767, -32768, 12, -12};
        run("R6 luma", 1, 600, 16, 0, 1002, dq, 1'b0);

        // R7: chroma 2x2
        dq = '{300, -300, 5, -64};
        run("R7 chroma", 2, 300, 20, 0, 8, dq, 1'b0);
        dq = '{-1000, 1000, 400, -400};
        run("R7 chroma", 2, 0, 8, 10, 9, dq, 1'b0);

        // R9: start pulses while busy
        dq = '{90, -90, 250, -250};
        run("R9 luma", 1, 100, 32, 1, 11, dq, 1'b1);
        run("R9 chroma", 2, 100, 32, 1, 12, dq, 1'b1);
        dq = '{-64, 0, 0, 0};
        run("R9 single", 0, 100, 32, 1, 13, dq, 1'b1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule